// File: doc/BRIEF.md
# Grouped-Priority Preemption Arbiter

This block decides which interrupt request line is served next and whether that request may interrupt the handler that is running now. Each of 60 request lines has a 4-bit priority code, which software sets through a plain 32-bit register bus. A group setting divides every code at run time into two parts. The upper part is the preemption level and the lower part is the sub-level. Lower numbers win.

Each cycle the block takes the vector of enabled, pending requests and picks one winner. The code is compared first. Among equal codes the line that has waited longest wins. Among lines that arrived in the same cycle, the lowest line number wins. The winner's preemption level is then compared with the level that is currently executing. The winner is taken only if its level is strictly lower in number. A taken level is pushed onto a nesting stack. A completion strobe pops the stack and restores the interrupted level.

Enable and pending bookkeeping, and dispatch to a handler address, are done by neighbouring logic.

Top module: `prio_preempt_arb`

## Requirements
- R1: Word addresses 0 to 14 hold the priority codes. Line 4n+k, for k from 0 to 3, uses byte k of word n, which is bits [8k+7:8k].
- R2: Only bits [7:4] of each byte are stored. Bits [3:0] of each byte always read back as zero.
- R3: Word address 15 is the control word. Bits [10:8] hold 7 minus the group number g. After reset the field holds 7 (g = 0), so the word reads 0x00000700. A write to the field takes effect only when bits [31:16] of the write data are 0x05FA.
- R4: A control write with any other key changes nothing. Bits [31:11] and [7:0] of the control word always read as zero.
- R5: A stored field value of 0, 1 or 2 behaves as g = 4. For group g, the preemption level of a code is the code with its low 4−g bits forced to zero.
- R6: The winner is the requesting line with the numerically smallest 4-bit code. This means the preemption level is compared first and the sub-level breaks ties.
- R7: Among requests with equal codes, the one that has been pending longest wins. The age count saturates at 2^AGE_W−1 cycles. Among requests that arrived in the same cycle, the lower line number wins.
- R8: A winner is taken only when its preemption level is strictly below the running level. An equal level with a better sub-level does not nest. The take is a one-cycle pulse on `take_o`, one clock after the decision, with the line number on `take_line_o`.
- R9: `run_level_o` shows the preemption level on top of the nesting stack. When nothing is running it shows 16, which loses to every level. It changes only on a take or a completion.
- R10: A pulse on `done_i` pops the stack and restores the interrupted level. A pulse on `done_i` while idle is ignored.
- R11: When `done_i` and a pending winner fall in the same cycle, the winner is compared against the level beneath the popped one. If the winner qualifies, it replaces the popped entry.
- R12: After reset nothing is running and no take is signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| req_i | input | N_LINES | Enabled and pending request lines |
| done_i | input | 1 | Completion strobe of the running handler |
| take_o | output | 1 | Preemption taken (one-cycle pulse) |
| take_line_o | output | LINE_W | Line number of the take |
| run_level_o | output | 5 | Running preemption level, 16 when idle |

## Verification
A completion strobe and a new take can fall in the same cycle. In that cycle the pop and the push must merge into one replacement of the top entry, and the winner must be judged against the level that is being restored.

The bench provokes this case in three ways:
- It holds requests pending behind a running handler and then pulses `done_i`.
- It does the same with a request whose level only beats the level underneath the top entry.
- It does the same with a first-come tie between two waiting lines.

A scoreboard queue holds the expected take line. It judges each case by the take line that follows and by the restored or replaced `run_level_o`.

// File: rtl/prio_arb_pkg.sv
package prio_arb_pkg;

    localparam int PRIO_W = 4;
    localparam int LVL_W  = PRIO_W + 1;

    localparam logic [LVL_W-1:0] LVL_IDLE  = 5'h10;
    localparam logic [15:0]      CTRL_KEY  = 16'h05FA;
    localparam logic [2:0]       GRP_RESET = 3'd7;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [LVL_W-1:0]  level_t;
    typedef logic [2:0]        grp_t;

    typedef struct packed {
        logic  valid;
        prio_t code;
    } cand_t;

    // stored field holds 7-g; out-of-range encodings saturate at g=4
    function automatic grp_t grp_decode(grp_t stored);
        return (stored < 3'd3) ? 3'd4 : (3'd7 - stored);
    endfunction

    function automatic prio_t pre_mask(grp_t g);
        prio_t m;
        m = '0;
        for (int b = 0; b < PRIO_W; b++) begin
            if (b >= PRIO_W - int'(g)) m[b] = 1'b1;
        end
        return m;
    endfunction

    function automatic level_t to_level(prio_t code, grp_t g);
        return {1'b0, code & pre_mask(g)};
    endfunction

endpackage

// File: rtl/prio_arb_regs.sv
module prio_arb_regs
    import prio_arb_pkg::*;
#(
    parameter int N_LINES = 60,
    parameter int ADDR_W  = 5
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       bus_sel,
    input  logic                       bus_we,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [31:0]                bus_wdata,
    output logic [31:0]                bus_rdata,
    output logic [N_LINES-1:0][PRIO_W-1:0] code_o,
    output grp_t                       grp_o
);
    localparam int N_WORDS = (N_LINES + 3) / 4;
    localparam int WIDX_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(N_WORDS);

    logic [N_WORDS-1:0][3:0][PRIO_W-1:0] code_q;
    grp_t                                grp_q;
    logic [WIDX_W-1:0]                   widx;
    logic                                hit_code;
    logic                                hit_ctrl;
    logic                                unused_wbits;

    assign widx         = bus_addr[WIDX_W-1:0];
    assign hit_code     = bus_sel && (bus_addr < CTRL_ADDR);
    assign hit_ctrl     = bus_sel && (bus_addr == CTRL_ADDR);
    assign unused_wbits = ^bus_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
            grp_q  <= GRP_RESET;
        end else if (bus_we) begin
            if (hit_ctrl && bus_wdata[31:16] == CTRL_KEY) begin
                grp_q <= bus_wdata[10:8];
            end
            if (hit_code) begin
                for (int k = 0; k < 4; k++) begin
                    code_q[widx][k] <= bus_wdata[8*k+4 +: PRIO_W];
                end
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (hit_ctrl) begin
            bus_rdata[10:8] = grp_q;
        end else if (hit_code) begin
            for (int k = 0; k < 4; k++) begin
                bus_rdata[8*k+4 +: PRIO_W] = code_q[widx][k];
            end
        end
    end

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        assign code_o[i] = code_q[i/4][i%4];
    end

    assign grp_o = grp_decode(grp_q);

endmodule

// File: rtl/prio_arb_age.sv
module prio_arb_age #(
    parameter int N_LINES = 60,
    parameter int AGE_W   = 8
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [N_LINES-1:0]              req_i,
    output logic [N_LINES-1:0][AGE_W-1:0]   age_o
);
    for (genvar i = 0; i < N_LINES; i++) begin : g_age
        logic [AGE_W-1:0] age_q;
        always_ff @(posedge clk) begin
            if (rst || !req_i[i]) begin
                age_q <= '0;
            end else if (age_q != '1) begin
                age_q <= age_q + AGE_W'(1);
            end
        end
        assign age_o[i] = age_q;
    end
endmodule

// File: rtl/prio_arb_pick.sv
module prio_arb_pick
    import prio_arb_pkg::*;
#(
    parameter int N_LINES = 60,
    parameter int AGE_W   = 8,
    parameter int LINE_W  = 6
) (
    input  logic [N_LINES-1:0]              req_i,
    input  logic [N_LINES-1:0][PRIO_W-1:0]  code_i,
    input  logic [N_LINES-1:0][AGE_W-1:0]   age_i,
    output cand_t                           win_o,
    output logic [LINE_W-1:0]               win_line_o
);
    localparam int KEY_W = PRIO_W + AGE_W;

    logic [KEY_W-1:0] best_key;
    logic [KEY_W-1:0] cand_key;

    // code first, then older (inverted age); strict compare keeps the lower line
    always_comb begin
        win_o      = '0;
        win_line_o = '0;
        best_key   = '1;
        cand_key   = '0;
        for (int i = 0; i < N_LINES; i++) begin
            cand_key = {code_i[i], ~age_i[i]};
            if (req_i[i] && (!win_o.valid || cand_key < best_key)) begin
                win_o.valid = 1'b1;
                win_o.code  = code_i[i];
                win_line_o  = LINE_W'(i);
                best_key    = cand_key;
            end
        end
    end
endmodule

// File: rtl/prio_arb_stack.sv
module prio_arb_stack
    import prio_arb_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   push_i,
    input  logic   pop_i,
    input  level_t level_i,
    output level_t top_o,
    output level_t below_o,
    output logic   full_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0][LVL_W-1:0] mem_q;
    logic [CNT_W-1:0]            cnt_q;
    logic [IDX_W-1:0]            top_idx;
    logic [IDX_W-1:0]            below_idx;
    logic                        do_pop;

    assign top_idx   = IDX_W'(cnt_q - CNT_W'(1));
    assign below_idx = IDX_W'(cnt_q - CNT_W'(2));
    assign do_pop    = pop_i && (cnt_q != '0);
    assign full_o    = (cnt_q == CNT_W'(DEPTH));
    assign top_o     = (cnt_q == '0) ? LVL_IDLE : mem_q[top_idx];
    assign below_o   = (cnt_q <= CNT_W'(1)) ? LVL_IDLE : mem_q[below_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            mem_q <= '0;
        end else begin
            if (push_i && do_pop) begin
                mem_q[top_idx] <= level_i;
            end else if (push_i && !full_o) begin
                mem_q[IDX_W'(cnt_q)] <= level_i;
                cnt_q <= cnt_q + CNT_W'(1);
            end else if (do_pop) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/prio_preempt_arb.sv
module prio_preempt_arb
    import prio_arb_pkg::*;
#(
    parameter int N_LINES    = 60,
    parameter int AGE_W      = 8,
    parameter int NEST_DEPTH = 16,
    parameter int ADDR_W     = 5,
    parameter int LINE_W     = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [N_LINES-1:0] req_i,
    input  logic               done_i,
    output logic               take_o,
    output logic [LINE_W-1:0]  take_line_o,
    output logic [LVL_W-1:0]   run_level_o
);
    logic [N_LINES-1:0][PRIO_W-1:0] code;
    logic [N_LINES-1:0][AGE_W-1:0]  age;
    grp_t                           grp;
    cand_t                          win;
    logic [LINE_W-1:0]              win_line;
    level_t                         win_lvl;
    level_t                         top_lvl;
    level_t                         below_lvl;
    level_t                         cmp_lvl;
    logic                           full;
    logic                           take_now;

    prio_arb_regs #(.N_LINES(N_LINES), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .code_o(code), .grp_o(grp)
    );

    prio_arb_age #(.N_LINES(N_LINES), .AGE_W(AGE_W)) u_age (
        .clk(clk), .rst(rst), .req_i(req_i), .age_o(age)
    );

    prio_arb_pick #(.N_LINES(N_LINES), .AGE_W(AGE_W), .LINE_W(LINE_W)) u_pick (
        .req_i(req_i), .code_i(code), .age_i(age),
        .win_o(win), .win_line_o(win_line)
    );

    // a completing handler hands the comparison to the level it uncovers
    assign win_lvl  = to_level(win.code, grp);
    assign cmp_lvl  = done_i ? below_lvl : top_lvl;
    assign take_now = win.valid && (win_lvl < cmp_lvl) && (!full || done_i);

    prio_arb_stack #(.DEPTH(NEST_DEPTH)) u_stack (
        .clk(clk), .rst(rst),
        .push_i(take_now), .pop_i(done_i), .level_i(win_lvl),
        .top_o(top_lvl), .below_o(below_lvl), .full_o(full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            take_o      <= 1'b0;
            take_line_o <= '0;
        end else begin
            take_o      <= take_now;
            take_line_o <= win_line;
        end
    end

    assign run_level_o = top_lvl;

endmodule

// File: rtl/prio_preempt_arb_chk.sv
module prio_preempt_arb_chk #(
    parameter int N_LINES = 60,
    parameter int ADDR_W  = 5,
    parameter int LINE_W  = 6
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_sel,
    input logic               bus_we,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [31:0]        bus_rdata,
    input logic [N_LINES-1:0] req_i,
    input logic               done_i,
    input logic               take_o,
    input logic [LINE_W-1:0]  take_line_o,
    input logic [4:0]         run_level_o
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'((N_LINES + 3) / 4);

    logic [N_LINES-1:0] req_q;
    always_ff @(posedge clk) req_q <= req_i;

    p_take_lowers_level_r8: assert property (@(posedge clk) disable iff (rst)
        (take_o && !$past(done_i)) |-> (run_level_o < $past(run_level_o)));

    p_level_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!take_o && !$past(done_i)) |-> $stable(run_level_o));

    p_idle_form_r9: assert property (@(posedge clk) disable iff (rst)
        run_level_o[4] |-> (run_level_o == 5'h10));

    p_ctrl_zero_bits_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_we && bus_addr == CTRL_ADDR)
            |-> (bus_rdata[31:11] == '0 && bus_rdata[7:0] == '0));

    p_low_nibbles_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_we && bus_addr < CTRL_ADDR)
            |-> ((bus_rdata & 32'h0F0F_0F0F) == '0));

    p_take_in_range_r6: assert property (@(posedge clk) disable iff (rst)
        take_o |-> ({1'b0, take_line_o} < (LINE_W+1)'(N_LINES)));

    p_take_was_requested_r6: assert property (@(posedge clk) disable iff (rst)
        take_o |-> req_q[take_line_o]);

endmodule

bind prio_preempt_arb prio_preempt_arb_chk #(
    .N_LINES(N_LINES), .ADDR_W(ADDR_W), .LINE_W(LINE_W)
) u_chk (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata), .req_i(req_i),
    .done_i(done_i), .take_o(take_o), .take_line_o(take_line_o),
    .run_level_o(run_level_o)
);

// File: tb/prio_preempt_arb_bench.sv
module prio_preempt_arb_bench;
    localparam int N  = 60;
    localparam int LW = 6;

    logic          clk = 1'b0;
    logic          rst;
    logic          bus_sel, bus_we;
    logic [4:0]    bus_addr;
    logic [31:0]   bus_wdata;
    wire  [31:0]   bus_rdata;
    logic [N-1:0]  req;
    logic          done;
    wire           take;
    wire  [LW-1:0] tline;
    wire  [4:0]    lvl;

    int   n_chk = 0;
    int   n_bad = 0;
    int   exp_q[$];
    bit   over = 1'b0;
    logic [31:0] shadow [15];

    always #10 clk = ~clk;

    prio_preempt_arb u_prio_preempt_arb (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .req_i(req), .done_i(done), .take_o(take), .take_line_o(tline),
        .run_level_o(lvl)
    );

    task automatic check(bit ok, string tag, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every take pulse
    always @(negedge clk) begin
        int e;
        if (!rst && take) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 take without expectation", tline, -1);
            end else begin
                e = exp_q.pop_front();
                check(tline == LW'(e), "R6/R7 take line", tline, e);
            end
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic wr(int a, logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 5'(a); bus_wdata = d;
        tick();
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd_chk(int a, logic [31:0] exp, string tag);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 5'(a);
        #2;
        check(bus_rdata == exp, tag, bus_rdata, exp);
        tick();
        bus_sel = 1'b0;
    endtask

    task automatic set_code(int line, logic [3:0] code);
        shadow[line/4][8*(line%4) +: 8] = {code, 4'h0};
        wr(line/4, shadow[line/4]);
    endtask

    task automatic lvl_chk(logic [4:0] exp, string tag);
        check(lvl == exp, tag, lvl, exp);
    endtask

    task automatic finish_done();
        done = 1'b1;
        tick();
        done = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!over) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R12: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0;
        bus_wdata = '0; req = '0; done = 1'b0;
        for (int w = 0; w < 15; w++) shadow[w] = '0;
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R12 reset state, R9 idle encoding, R3 reset group field
        check(take == 1'b0, "R12 no take after reset", take, 0);
        lvl_chk(5'd16, "R9 idle level after reset");
        rd_chk(15, 32'h0000_0700, "R3 control after reset");

        // R1 packing and R2 low nibbles
        wr(2, 32'hA5C3_7F18);
        rd_chk(2, 32'hA0C0_7010, "R1 R2 word 2 readback");
        wr(14, 32'hFFFF_FFFF);
        rd_chk(14, 32'hF0F0_F0F0, "R2 last word readback");
        wr(2, 32'h0); wr(14, 32'h0);
        rd_chk(2, 32'h0, "R1 word 2 cleared");

        // R4 wrong key, R3 keyed write
        wr(15, 32'h1234_0500);
        rd_chk(15, 32'h0000_0700, "R4 wrong key ignored");
        wr(15, 32'h05FA_FFFF);
        rd_chk(15, 32'h0000_0700, "R4 only field bits stored");
        wr(15, 32'h05FA_0500);
        rd_chk(15, 32'h0000_0500, "R3 keyed write g=2");

        // g=2: preemption level = code & 0xC
        set_code(3, 4'h7); set_code(6, 4'h8); set_code(7, 4'h6);
        rd_chk(0, 32'h7000_0000, "R1 line 3 in byte 3 of word 0");
        rd_chk(1, 32'h6080_0000, "R1 lines 6,7 in word 1");

        exp_q.push_back(7);
        req[3] = 1'b1; req[6] = 1'b1; req[7] = 1'b1;
        tick();
        req[7] = 1'b0;
        lvl_chk(5'd4, "R6 smallest code wins, level 4");
        repeat (3) tick();
        lvl_chk(5'd4, "R8 equal level no nest");
        exp_q.push_back(3);
        finish_done();
        lvl_chk(5'd4, "R11 done with take replaces top");
        req[3] = 1'b0;
        exp_q.push_back(6);
        finish_done();
        lvl_chk(5'd8, "R11 next winner after done");

        exp_q.push_back(3);
        req[3] = 1'b1;
        tick();
        req[3] = 1'b0;
        lvl_chk(5'd4, "R8 strictly higher nests");
        req[7] = 1'b1;
        repeat (3) tick();
        lvl_chk(5'd4, "R8 better sub-level does not nest");
        exp_q.push_back(7);
        finish_done();
        lvl_chk(5'd4, "R11 winner beats restored level");
        req[7] = 1'b0;
        finish_done();
        lvl_chk(5'd8, "R10 pop restores level 8");
        req[6] = 1'b0;
        finish_done();
        lvl_chk(5'd16, "R10 pop to idle");
        finish_done();
        lvl_chk(5'd16, "R10 done while idle ignored");

        // R5 clamp: stored 1 behaves as g=4
        wr(15, 32'h05FA_0100);
        rd_chk(15, 32'h0000_0100, "R3 stored 1 reads back");
        exp_q.push_back(3);
        req[3] = 1'b1; tick(); req[3] = 1'b0;
        lvl_chk(5'd7, "R5 g=4 full code is level");
        exp_q.push_back(7);
        req[7] = 1'b1; tick(); req[7] = 1'b0;
        lvl_chk(5'd6, "R5 g=4 code 6 nests over 7");
        finish_done();
        lvl_chk(5'd7, "R10 restore 7");
        finish_done();

        // g=0: every level is 0, nothing nests
        wr(15, 32'h05FA_0700);
        exp_q.push_back(6);
        req[6] = 1'b1; tick(); req[6] = 1'b0;
        lvl_chk(5'd0, "R5 g=0 level 0");
        req[7] = 1'b1;
        repeat (3) tick();
        exp_q.push_back(7);
        finish_done();
        req[7] = 1'b0;
        lvl_chk(5'd0, "R11 g=0 served on completion");
        finish_done();
        lvl_chk(5'd16, "R10 idle after g=0 run");

        // R7 same-cycle tie: lower line
        wr(15, 32'h05FA_0500);
        set_code(20, 4'h5); set_code(40, 4'h5); set_code(10, 4'h0);
        exp_q.push_back(20);
        req[20] = 1'b1; req[40] = 1'b1;
        tick();
        req[20] = 1'b0; req[40] = 1'b0;
        lvl_chk(5'd4, "R7 same-cycle tie level");
        finish_done();

        // R7 first-come: line 40 waits longer than line 20
        exp_q.push_back(10);
        req[10] = 1'b1; tick(); req[10] = 1'b0;
        lvl_chk(5'd0, "R8 line 10 at level 0");
        req[40] = 1'b1;
        repeat (2) tick();
        req[20] = 1'b1;
        repeat (2) tick();
        exp_q.push_back(40);
        finish_done();
        req[40] = 1'b0;
        lvl_chk(5'd4, "R7 older request served first");
        exp_q.push_back(20);
        finish_done();
        req[20] = 1'b0;
        lvl_chk(5'd4, "R11 later request after completion");
        finish_done();
        lvl_chk(5'd16, "R10 idle after tie test");

        // deeper nesting under g=4
        wr(15, 32'h05FA_0300);
        set_code(50, 4'hC); set_code(51, 4'h9); set_code(52, 4'h3); set_code(53, 4'h1);
        for (int i = 50; i < 54; i++) begin
            exp_q.push_back(i);
            req[i] = 1'b1; tick(); req[i] = 1'b0;
        end
        lvl_chk(5'd1, "R8 four-deep nest level 1");
        finish_done(); lvl_chk(5'd3,  "R10 restore 3");
        finish_done(); lvl_chk(5'd9,  "R10 restore 9");
        finish_done(); lvl_chk(5'd12, "R10 restore 12");
        finish_done(); lvl_chk(5'd16, "R10 restore idle");

        repeat (2) tick();
        check(exp_q.size() == 0, "R8 all expected takes seen", exp_q.size(), 0);

        over = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule